// File: doc/BRIEF.md
# Masked Level Interrupt Concentrator

This block gathers a set of level-sensitive interrupt request lines into a pending register, qualifies them against a software-controlled enable mask and raises one combined interrupt line towards the processor. Each pending bit tracks its request line: it sets while the line is high and clears when the line drops. No acknowledge is needed and nothing is latched on an edge.

Software reaches the block through a 16-bit register port. Reading the vector offset returns a code for the most urgent enabled pending request. The code is (index + 1) shifted left by two, and lower indices are more urgent. The read returns zero when nothing enabled is pending. A second offset holds the enable mask. Its reset value is 0x0010, so only request 4 is enabled after reset.

Top module: `irq_concentrator`

## Requirements
- R1: Every clock, pending bit n takes the level of request line n. A change on a line shows up on the outputs one clock edge after it is sampled.
- R2: `irqOut` is high exactly when the pending bits ANDed with the enable mask give a nonzero value. It follows a change of the pending bits and a mask write from the edge that registers them.
- R3: A read at byte offset 0x000 returns ((n + 1) << 2), where n is the lowest-numbered request that is both pending and enabled. It returns 0 when no such request exists.
- R4: When several enabled requests are pending, the lowest index wins the vector: index 0 is the most urgent and index 15 the least.
- R5: Byte offset 0x002 holds the enable mask. Bit n enables request n. A write there stores all 16 data bits, and a read there returns them.
- R6: A write to any offset other than 0x002, including the vector offset 0x000, leaves the mask unchanged.
- R7: During and after reset the mask is 0x0010, all pending bits are 0 and `irqOut` is low.
- R8: A read at any offset other than 0x000 and 0x002 returns 0.
- R9: Reading the vector has no side effect. A pending request stays pending, and keeps the vector and `irqOut`, until its line goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | 16 | Level-sensitive request lines |
| busAddr | input | 12 | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe, captured on the rising edge |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Combined interrupt request |

## Verification
A request level is registered on the first rising edge after it is applied. Both `irqOut` and the vector therefore change one edge after the bench drives a line on a falling edge. The bench samples them just after that rising edge, and once before it to confirm the one-cycle latency. A mask write takes effect on the edge that captures it, and the bench checks `irqOut` and the read-back right after that edge. Read data is combinational from the address and the registers, so each read is sampled a short delay after the bench sets the offset on a falling edge.

// File: rtl/irq_conc_pkg.sv
package irq_conc_pkg;
  typedef struct packed {
    logic maskWr;
    logic selVec;
    logic selMask;
  } regStrobe_t;
endpackage

// File: rtl/irq_conc_ctrl.sv
module irq_conc_ctrl
  import irq_conc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int VEC_OFS  = 0,
  parameter int MASK_OFS = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] VecAddr  = ADDR_W'(VEC_OFS);
  localparam logic [ADDR_W-1:0] MaskAddr = ADDR_W'(MASK_OFS);

  always_comb begin
    strobe.selVec  = (busAddr == VecAddr);
    strobe.selMask = (busAddr == MaskAddr);
    strobe.maskWr  = busWrEn && (busAddr == MaskAddr);
  end
endmodule

// File: rtl/irq_conc_dp.sv
module irq_conc_dp
  import irq_conc_pkg::*;
#(
  parameter int                  NUM_SRC  = 16,
  parameter int                  DATA_W   = 16,
  parameter logic [NUM_SRC-1:0]  MASK_RST = NUM_SRC'(16'h0010)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [DATA_W-1:0]  busWrData,
  input  regStrobe_t         strobe,
  output logic [DATA_W-1:0]  busRdData,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] pendReg;
  logic [NUM_SRC-1:0] maskReg;
  logic [NUM_SRC-1:0] active;
  logic [DATA_W-1:0]  vecCode;
  logic               warm;

  function automatic logic [DATA_W-1:0] encVec(input logic [NUM_SRC-1:0] p);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (p[i]) v = DATA_W'((i + 1) << 2);
    end
    return v;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendReg <= '0;
      maskReg <= MASK_RST;
      warm    <= 1'b0;
    end else begin
      pendReg <= irqIn;
      warm    <= 1'b1;
      if (strobe.maskWr) maskReg <= busWrData[NUM_SRC-1:0];
    end
  end

  always_comb begin
    active  = pendReg & maskReg;
    irqOut  = |active;
    vecCode = encVec(active);
    if (strobe.selVec)       busRdData = vecCode;
    else if (strobe.selMask) busRdData = DATA_W'(maskReg);
    else                     busRdData = '0;
  end

  // R1: pending bits follow the sampled request levels
  a_r1_pend_follows: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> pendReg == $past(irqIn));
  // R5: a mask write stores the written data
  a_r5_mask_store: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskWr |=> maskReg == $past(busWrData[NUM_SRC-1:0]));
  // R6: the mask only changes on a mask write
  a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.maskWr |=> $stable(maskReg));
  // R3: the vector is nonzero exactly when the combined line is high
  a_r3_vec_vs_irq: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selVec |-> ((busRdData != '0) == irqOut));
  // R3: vector codes keep the two low bits clear
  a_r3_vec_align: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selVec |-> busRdData[1:0] == 2'b00);
  // R7: nothing enabled can be pending right after reset
  a_r7_quiet_start: assert property (@(posedge clk) disable iff (!rstN)
    !warm |-> !irqOut);
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
  import irq_conc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  output logic               irqOut
);
  regStrobe_t strobe;

  irq_conc_ctrl #(.ADDR_W(ADDR_W), .VEC_OFS(0), .MASK_OFS(2)) uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  irq_conc_dp #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W),
                .MASK_RST(NUM_SRC'(16'h0010))) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .busWrData (busWrData),
    .strobe    (strobe),
    .busRdData (busRdData),
    .irqOut    (irqOut)
  );

  // R8: unknown offsets read as zero
  a_r8_unknown_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != 12'h000 && busAddr != 12'h002) |-> busRdData == '0);
endmodule

// File: tb/tb_irq_concentrator.sv
module tb_irq_concentrator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqIn = '0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        irqOut;
  int checks = 0;
  int errors = 0;
  logic [15:0] maskModel = 16'h0010;
  logic [15:0] lvlModel = '0;

  irq_concentrator dut (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expVec(input logic [15:0] p);
    for (int i = 0; i < 16; i++) if (p[i]) return 16'((i + 1) * 4);
    return 16'h0;
  endfunction

  task automatic drive(input logic [15:0] v);
    @(negedge clk); irqIn = v; lvlModel = v;
    @(posedge clk); #1;
  endtask

  task automatic writeReg(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1'b1;
    if (a == 12'h002) maskModel = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); busAddr = a; #1; d = busRdData;
  endtask

  task automatic checkState(input string req);
    logic [15:0] d;
    check(req, irqOut, |(lvlModel & maskModel));
    readReg(12'h000, d);
    check(req, d, expVec(lvlModel & maskModel));
  endtask

  task automatic tReset();
    logic [15:0] d;
    check("R7 irq at reset", irqOut, 0);
    readReg(12'h002, d); check("R7 mask reset", d, 16'h0010);
    readReg(12'h000, d); check("R7 vector reset", d, 0);
  endtask

  task automatic tDefaultMask();
    drive(16'h0004); checkState("R2 masked source ignored");
    drive(16'h0010); checkState("R3 enabled source 4");
  endtask

  task automatic tLatency();
    @(negedge clk); irqIn = 16'h0000; lvlModel = 16'h0000;
    #1 check("R1 no change before edge", irqOut, 1);
    @(posedge clk); #1;
    check("R1 cleared after edge", irqOut, 0);
  endtask

  task automatic tMaskWrite();
    logic [15:0] d;
    drive(16'h0100); checkState("R2 pending but masked");
    writeReg(12'h002, 16'hFFFF);
    check("R2 irq after mask write", irqOut, 1);
    readReg(12'h002, d); check("R5 mask readback", d, 16'hFFFF);
    writeReg(12'h002, 16'h0000);
    check("R2 irq off with zero mask", irqOut, 0);
    writeReg(12'h002, 16'hA5C3);
    readReg(12'h002, d); check("R5 mask pattern", d, 16'hA5C3);
    writeReg(12'h002, 16'hFFFF);
  endtask

  task automatic tPriority();
    drive(16'h8300); checkState("R4 lowest of 8,9,15");
    drive(16'h8000); checkState("R3 index 15 code 64");
    check("R3 index 15 code value", expVec(16'h8000), 16'd64);
    drive(16'hFFFF); checkState("R4 all pending picks 0");
    drive(16'h0001); checkState("R3 index 0 code 4");
  endtask

  task automatic tIgnoredWrites();
    logic [15:0] d;
    writeReg(12'h000, 16'h0000);
    writeReg(12'h004, 16'h1234);
    writeReg(12'h003, 16'h0000);
    readReg(12'h002, d); check("R6 mask unchanged", d, 16'hFFFF);
    check("R6 irq unchanged", irqOut, 1);
  endtask

  task automatic tUnknownReads();
    logic [15:0] d;
    readReg(12'h006, d); check("R8 read 0x006", d, 0);
    readReg(12'h001, d); check("R8 read 0x001", d, 0);
    readReg(12'h800, d); check("R8 read 0x800", d, 0);
  endtask

  task automatic tNoSideEffect();
    logic [15:0] d;
    drive(16'h0020);
    readReg(12'h000, d); check("R9 first read", d, 16'd24);
    @(posedge clk); #1;
    readReg(12'h000, d); check("R9 second read", d, 16'd24);
    check("R9 irq held", irqOut, 1);
    drive(16'h0000); checkState("R9 clears on level drop");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 tReset();
        @(negedge clk); rstN = 1'b1;
        tReset();
        tDefaultMask();
        tLatency();
        tMaskWrite();
        tPriority();
        tIgnoredWrites();
        tUnknownReads();
        tNoSideEffect();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule